// File: doc/BRIEF.md
# Byte-Stream Register Packet Decoder

This block sits behind a host byte link and turns a stream of bytes into register accesses. It frames the stream into four-byte command packets. Each packet is a start marker of 0xFF, an address byte, and a 16-bit payload sent most significant byte first. The top bit of the address byte selects a read or a write. The lower seven bits index a small register file that lives outside the block. The block drives that register file through a one-cycle write strobe and a combinational read port.

A write packet changes a register only after its fourth byte has been accepted. A packet that stalls partway through, or is cut short, leaves every register untouched. A read packet has the same layout as a write; its payload bytes are don't-care. The block answers on a separate byte output with a four-byte packet of the same shape.

Both byte streams use valid/ready handshakes. A byte moves only in a cycle where both valid and ready are high. On the output side, the block holds `resp_valid` and `resp_byte` steady until the sink takes the byte. On the input side, the block lowers `cmd_ready` from the moment a read packet completes until the last response byte has been taken. The host therefore cannot start another packet while a reply is pending.

Top module: `regpkt_decoder`

## Requirements
- R1: A packet is the byte 0xFF, then an address byte, then the payload high byte, then the payload low byte. An input byte counts only in a cycle where `cmd_valid` and `cmd_ready` are both 1.
- R2: If address bit 7 is 0 and the index in bits 6:0 is below `NUM_REGS`, `reg_wr_en` is 1 for exactly one cycle, in the cycle right after the low byte is accepted. During that cycle `reg_wr_addr` carries the index and `reg_wr_data` carries {high byte, low byte}.
- R3: If address bit 7 is 1, the block sends four bytes on the response stream. They are 0xFF, then the address byte as received (bit 7 set), then the register's high byte, then its low byte.
- R4: `reg_wr_en` never rises before the fourth byte of a packet has been accepted.
- R5: While waiting for a packet, every byte other than 0xFF is accepted and discarded.
- R6: A 0xFF received where the address byte is expected restarts the packet. The byte that follows it is then taken as the address.
- R7: Once a packet has started, if `TIMEOUT` consecutive cycles pass with no accepted byte, the block drops the partial packet and waits for a new 0xFF.
- R8: A byte accepted in the cycle in which the timeout would expire (`TIMEOUT-1` empty cycles after the previous byte) continues the packet.
- R9: A write to an index at or above `NUM_REGS` produces no `reg_wr_en`. A read from such an index returns the data 0x0000.
- R10: While `resp_valid` is 1 and `resp_ready` is 0, `resp_valid` and `resp_byte` hold. `cmd_ready` is 0 from the cycle after a read packet's last byte until the response's last byte is taken.
- R11: After reset, `cmd_ready` is 1 and `resp_valid` and `reg_wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Input byte valid |
| cmd_byte | input | 8 | Input byte |
| cmd_ready | output | 1 | Block can accept an input byte |
| resp_valid | output | 1 | Response byte valid |
| resp_byte | output | 8 | Response byte |
| resp_ready | input | 1 | Sink accepts the response byte |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 7 | Register index for the write |
| reg_wr_data | output | 16 | Data to write |
| reg_rd_addr | output | 7 | Register index for the read |
| reg_rd_data | input | 16 | Register contents at `reg_rd_addr` |

## Verification
The inter-byte timeout and the arrival of a payload byte can fall in the same cycle. The bench provokes this by stalling for exactly `TIMEOUT-1` empty cycles before the last byte, and then for exactly `TIMEOUT` cycles. In the first case the write must commit with the expected data. In the second the late byte must be discarded as idle noise. In both cases the outcome is judged from the write-strobe count and by reading the register back over the response stream.

// File: rtl/regpkt_pkg.sv
package regpkt_pkg;
  localparam logic [7:0] START_BYTE = 8'hFF;
  localparam int IDX_W  = 7;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_ADDR = 2'd1,
    FR_HIGH = 2'd2,
    FR_LOW  = 2'd3
  } frame_state_e;
endpackage

// File: rtl/regpkt_framer.sv
module regpkt_framer
  import regpkt_pkg::*;
#(
  parameter int TIMEOUT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_take,
  input  logic [7:0]        byte_in,
  output logic              pkt_done,
  output logic              pkt_is_read,
  output logic [IDX_W-1:0]  pkt_idx,
  output logic [WORD_W-1:0] pkt_word
);
  localparam int CW = $clog2(TIMEOUT + 1);

  frame_state_e      state_q;
  logic [CW-1:0]     stall_q;
  logic [7:0]        high_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= FR_IDLE;
      stall_q     <= '0;
      high_q      <= '0;
      pkt_done    <= 1'b0;
      pkt_is_read <= 1'b0;
      pkt_idx     <= '0;
      pkt_word    <= '0;
    end else begin
      pkt_done <= 1'b0;
      if (byte_take) begin
        stall_q <= '0;
        unique case (state_q)
          FR_IDLE: if (byte_in == START_BYTE) state_q <= FR_ADDR;
          FR_ADDR: begin
            // a repeated start byte resynchronises (R6)
            if (byte_in != START_BYTE) begin
              pkt_is_read <= byte_in[7];
              pkt_idx     <= byte_in[IDX_W-1:0];
              state_q     <= FR_HIGH;
            end
          end
          FR_HIGH: begin
            high_q  <= byte_in;
            state_q <= FR_LOW;
          end
          FR_LOW: begin
            pkt_word <= {high_q, byte_in};
            pkt_done <= 1'b1;
            state_q  <= FR_IDLE;
          end
          default: state_q <= FR_IDLE;
        endcase
      end else if (state_q != FR_IDLE) begin
        // stall watchdog inside a packet (R7); an accepted byte wins (R8)
        if (stall_q == CW'(TIMEOUT - 1)) begin
          state_q <= FR_IDLE;
          stall_q <= '0;
        end else begin
          stall_q <= stall_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/regpkt_responder.sv
module regpkt_responder
  import regpkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] word,
  output logic              busy,
  output logic              out_valid,
  output logic [7:0]        out_byte,
  input  logic              out_ready
);
  logic [31:0] frame_q;
  logic [1:0]  pos_q;

  assign out_valid = busy;
  assign out_byte  = frame_q[31:24];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      pos_q   <= '0;
      frame_q <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      pos_q   <= '0;
      frame_q <= {START_BYTE, 1'b1, idx, word};
    end else if (busy && out_ready) begin
      frame_q <= {frame_q[23:0], 8'h00};
      pos_q   <= pos_q + 1'b1;
      if (pos_q == 2'd3) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/regpkt_decoder.sv
module regpkt_decoder
  import regpkt_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int TIMEOUT  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_byte,
  output logic        cmd_ready,
  output logic        resp_valid,
  output logic [7:0]  resp_byte,
  input  logic        resp_ready,
  output logic        reg_wr_en,
  output logic [6:0]  reg_wr_addr,
  output logic [15:0] reg_wr_data,
  output logic [6:0]  reg_rd_addr,
  input  logic [15:0] reg_rd_data
);
  logic              take;
  logic              done;
  logic              is_read;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word;
  logic              resp_busy;
  logic              mapped;
  logic              rd_load;

  assign mapped    = int'(idx) < NUM_REGS;
  assign rd_load   = done && is_read;
  assign cmd_ready = !resp_busy && !rd_load;
  assign take      = cmd_valid && cmd_ready;

  regpkt_framer #(.TIMEOUT(TIMEOUT)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_take  (take),
    .byte_in    (cmd_byte),
    .pkt_done   (done),
    .pkt_is_read(is_read),
    .pkt_idx    (idx),
    .pkt_word   (word)
  );

  // commit only on a finished write to a mapped index (R2, R9)
  assign reg_wr_en   = done && !is_read && mapped;
  assign reg_wr_addr = idx;
  assign reg_wr_data = word;
  assign reg_rd_addr = idx;

  regpkt_responder u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rd_load),
    .idx      (idx),
    .word     (mapped ? reg_rd_data : '0),
    .busy     (resp_busy),
    .out_valid(resp_valid),
    .out_byte (resp_byte),
    .out_ready(resp_ready)
  );
endmodule

// File: rtl/regpkt_decoder_chk.sv
module regpkt_decoder_chk #(
  parameter int NUM_REGS = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       resp_valid,
  input logic [7:0] resp_byte,
  input logic       resp_ready,
  input logic       reg_wr_en,
  input logic [6:0] reg_wr_addr
);
  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_byte));

  a_r10_in_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !cmd_ready);

  a_r9_wr_mapped: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> int'(reg_wr_addr) < NUM_REGS);

  a_r2_wr_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> $past(cmd_valid && cmd_ready));

  a_r4_wr_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);
endmodule

bind regpkt_decoder regpkt_decoder_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .resp_valid (resp_valid),
  .resp_byte  (resp_byte),
  .resp_ready (resp_ready),
  .reg_wr_en  (reg_wr_en),
  .reg_wr_addr(reg_wr_addr)
);

// File: tb/regpkt_decoder_tb.sv
module regpkt_decoder_tb;
  localparam int NREG = 16;
  localparam int TMO  = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_byte = '0;
  logic        cmd_ready;
  logic        resp_valid;
  logic [7:0]  resp_byte;
  logic        resp_ready = 1'b0;
  logic        reg_wr_en;
  logic [6:0]  reg_wr_addr;
  logic [15:0] reg_wr_data;
  logic [6:0]  reg_rd_addr;
  logic [15:0] reg_rd_data;

  int tests = 0;
  int fails = 0;
  int wr_cnt = 0;
  logic [15:0] rf [128];

  always #2 clk = ~clk;

  regpkt_decoder #(.NUM_REGS(NREG), .TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_ready(cmd_ready),
    .resp_valid(resp_valid), .resp_byte(resp_byte), .resp_ready(resp_ready),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
  );

  // external register file model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) rf[i] <= '0;
    end else if (reg_wr_en) begin
      rf[reg_wr_addr] <= reg_wr_data;
      wr_cnt <= wr_cnt + 1;
    end
  end
  assign reg_rd_data = (int'(reg_rd_addr) < NREG) ? rf[reg_rd_addr] : 16'hDEAD;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called just after a negedge; returns just after the next negedge
  task automatic send_byte(input logic [7:0] b);
    logic r;
    cmd_valid = 1'b1;
    cmd_byte  = b;
    do begin
      r = cmd_ready;
      @(posedge clk);
    end while (!r);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pkt(input logic [7:0] a, input logic [15:0] d);
    send_byte(8'hFF); send_byte(a); send_byte(d[15:8]); send_byte(d[7:0]);
  endtask

  task automatic get_resp(output logic [31:0] f);
    resp_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      while (!resp_valid) @(negedge clk);
      f = {f[23:0], resp_byte};
      @(negedge clk);
    end
    resp_ready = 1'b0;
  endtask

  task automatic read_chk(input int idx, input logic [15:0] exp, input string tag);
    logic [31:0] f;
    logic [31:0] e;
    send_pkt(8'h80 | 8'(idx), 16'h0000);
    get_resp(f);
    e = {8'hFF, 8'h80 | 8'(idx), exp};
    check(f == e, tag, f, e);
  endtask

  task automatic t_reset;
    check(cmd_ready == 1'b1, "R11 cmd_ready", cmd_ready, 1);
    check(resp_valid == 1'b0, "R11 resp_valid", resp_valid, 0);
    check(reg_wr_en == 1'b0, "R11 reg_wr_en", reg_wr_en, 0);
  endtask

  task automatic t_write_read;
    int c0 = wr_cnt;
    send_byte(8'hFF); send_byte(8'h02); send_byte(8'hBE); send_byte(8'hEF);
    // strobe registered at the low-byte edge, visible now
    check(reg_wr_en == 1'b1, "R2 strobe", reg_wr_en, 1);
    check(reg_wr_addr == 7'd2 && reg_wr_data == 16'hBEEF, "R2 fields",
          {reg_wr_addr, reg_wr_data}, {7'd2, 16'hBEEF});
    gap(1);
    check(wr_cnt == c0 + 1, "R2 one pulse", wr_cnt - c0, 1);
    read_chk(2, 16'hBEEF, "R1 R3 readback");
  endtask

  task automatic t_idle_noise;
    send_byte(8'h12); send_byte(8'h05); send_byte(8'h00); send_byte(8'hA5);
    send_pkt(8'h05, 16'h1357);
    gap(2);
    read_chk(5, 16'h1357, "R5 noise ignored");
  endtask

  task automatic t_resync;
    send_byte(8'hFF); send_byte(8'hFF); send_byte(8'hFF);
    send_byte(8'h06); send_byte(8'h24); send_byte(8'h68);
    gap(2);
    read_chk(6, 16'h2468, "R6 resync");
  endtask

  task automatic t_partial;
    int c0 = wr_cnt;
    send_byte(8'hFF); send_byte(8'h07); send_byte(8'hAB);
    gap(3);
    check(wr_cnt == c0, "R4 no early write", wr_cnt - c0, 0);
    send_byte(8'hCD);
    gap(1);
    check(wr_cnt == c0 + 1, "R4 write on last byte", wr_cnt - c0, 1);
    read_chk(7, 16'hABCD, "R4 data");
  endtask

  task automatic t_timeout;
    int c0 = wr_cnt;
    send_byte(8'hFF); send_byte(8'h03); send_byte(8'h12);
    gap(TMO);
    send_byte(8'h34);
    gap(2);
    check(wr_cnt == c0, "R7 stalled packet dropped", wr_cnt - c0, 0);
    read_chk(3, 16'h0000, "R7 register untouched");
    c0 = wr_cnt;
    send_byte(8'hFF); send_byte(8'h03); send_byte(8'h12);
    gap(TMO - 1);
    send_byte(8'h34);
    gap(1);
    check(wr_cnt == c0 + 1, "R8 last-cycle byte kept", wr_cnt - c0, 1);
    read_chk(3, 16'h1234, "R8 data");
  endtask

  task automatic t_unmapped;
    int c0 = wr_cnt;
    send_pkt(8'h10, 16'h5555);
    send_pkt(8'h7E, 16'hAAAA);
    gap(2);
    check(wr_cnt == c0, "R9 unmapped write", wr_cnt - c0, 0);
    read_chk(16'h10, 16'h0000, "R9 unmapped read zero");
    read_chk(5, 16'h1357, "R9 mapped unchanged");
  endtask

  task automatic t_backpressure;
    logic [31:0] f;
    send_pkt(8'h82, 16'h0000);
    gap(5);
    check(resp_valid == 1'b1 && resp_byte == 8'hFF, "R10 held first byte",
          {resp_valid, resp_byte}, {1'b1, 8'hFF});
    check(cmd_ready == 1'b0, "R10 input blocked", cmd_ready, 0);
    get_resp(f);
    check(f == 32'hFF82BEEF, "R10 frame after stall", f, 32'hFF82BEEF);
    check(cmd_ready == 1'b1, "R10 input reopened", cmd_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    gap(1);
    t_write_read();
    t_idle_noise();
    t_resync();
    t_partial();
    t_timeout();
    t_unmapped();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule